// File: doc/BRIEF.md
# Trace Byte Staging Buffer with Overflow Stall

This block sits between a producer of decoded trace bytes and an output packet port that is allowed to turn data away. The producer hands over bytes in chunks of 1 to 16, one byte per clock. When a chunk starts, the block first offers it straight to the output port. If the port takes the offer, the chunk streams out unchanged. If the port turns it down, the chunk is copied into a 64-byte holding store, placed after the bytes already held.

When a refused chunk does not fit, the block does not push back on the producer. Instead it empties the holding store, drops the chunk and raises a sticky stall flag, which stays set until an external clear pulse. A separate drain request sends the whole holding store out as a single packet and then empties it. While a drain is pending or under way, the block reports busy and ignores new chunk starts.

Top module: `trace_stage_buf`

## Requirements
- R1: The holding store keeps up to 64 bytes. A refused chunk that brings the held count to exactly 64 is stored without raising stall.
- R2: A valid chunk start raises `pktOffer` in that same cycle, with `pktOfferLen` equal to `chunkLen`. If `pktAccept` is high in that cycle, each chunk byte appears on `pktByte` with `pktValid` one cycle after it is presented. `pktLast` is high on the final byte, and nothing is stored.
- R3: A refused chunk that fits is appended after the bytes already held, keeping arrival order.
- R4: A refused chunk for which the held count plus `chunkLen` exceeds 64 sets `stall`, clears the held count to zero and is dropped.
- R5: A drain request with a nonzero held count emits every held byte in arrival order as one packet, with `pktLast` on the last byte. The held count then becomes zero.
- R6: A drain request with a zero held count emits nothing.
- R7: `stall` stays high until `stallClr` is pulsed. If an overflow and `stallClr` fall in the same cycle, `stall` ends up high.
- R8: While a drain is pending or being emitted, `chunkBusy` is high. A chunk start in that time raises no offer and neither stores nor emits anything.
- R9: If a drain request and a chunk start arrive in the same idle cycle, the chunk is handled first. The drain follows and includes that chunk if it was stored.
- R10: A chunk start with `chunkLen` equal to 0 or greater than 16 is ignored: no offer, nothing stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chunkStart | input | 1 | First-byte strobe of a chunk |
| chunkLen | input | 5 | Chunk length in bytes, valid with chunkStart |
| chunkByte | input | 8 | Chunk byte, one per cycle starting with chunkStart |
| chunkBusy | output | 1 | Drain pending or in progress; chunk starts ignored |
| pktOffer | output | 1 | Direct offer of the starting chunk to the port |
| pktOfferLen | output | 5 | Length of the offered chunk |
| pktAccept | input | 1 | Port takes the offered chunk (same cycle as pktOffer) |
| pktValid | output | 1 | Output byte valid |
| pktByte | output | 8 | Output byte |
| pktLast | output | 1 | Final byte of the output packet |
| drainReq | input | 1 | Request to send the whole holding store |
| stallClr | input | 1 | Clears the stall flag |
| stall | output | 1 | Sticky overflow indication |

## Verification
Two pairs of functions can fall in the same cycle here. A drain request can arrive together with a chunk start, and an overflowing chunk can arrive together with a stall clear. The bench drives each pair on the same clock edge. For the first pair it judges the result by the content of the drain packet that follows, which must include the just-staged chunk. For the second pair it samples `stall` after that edge and expects it high. Random chunk traffic with random acceptance and occasional drains and clears is compared byte by byte against a queue model of the holding store.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIRECT,
    ST_STAGE,
    ST_SKIP,
    ST_DRAIN
  } tsb_state_e;

  typedef struct packed {
    logic wrEn;
    logic passEn;
    logic passLast;
    logic rdEn;
    logic rdLast;
  } tsb_strb_t;
endpackage

// File: rtl/tsb_ctrl.sv
module tsb_ctrl
  import tsb_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int MAX_CHUNK = 16,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LEN_W  = $clog2(MAX_CHUNK + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chunkStart,
  input  logic [LEN_W-1:0]  chunkLen,
  input  logic              pktAccept,
  input  logic              drainReq,
  input  logic              stallClr,
  output tsb_strb_t         strb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              chunkBusy,
  output logic              pktOffer,
  output logic              stall
);
  tsb_state_e       state;
  logic [LEN_W-1:0] idx, lenR;
  logic [CNT_W-1:0] held, baseR, rdIdx;
  logic             drainPend, stallR;

  logic             idle, lenOk, startOk, fits, inChunk, byteAct, ovf, serve;
  logic [CNT_W:0]   sum;
  tsb_state_e       startMode, curMode;
  logic [LEN_W-1:0] curIdx, curLen;
  logic [CNT_W-1:0] curBase, wrFull;

  always_comb begin
    idle      = (state == ST_IDLE);
    lenOk     = (chunkLen != '0) && (chunkLen <= LEN_W'(MAX_CHUNK));
    startOk   = idle && !drainPend && chunkStart && lenOk;
    sum       = {1'b0, held} + (CNT_W+1)'(chunkLen);
    fits      = (sum <= (CNT_W+1)'(DEPTH));
    startMode = pktAccept ? ST_DIRECT : (fits ? ST_STAGE : ST_SKIP);
    inChunk   = (state == ST_DIRECT) || (state == ST_STAGE) || (state == ST_SKIP);
    curMode   = startOk ? startMode : state;
    curIdx    = startOk ? '0 : idx;
    curLen    = startOk ? chunkLen : lenR;
    curBase   = startOk ? held : baseR;
    byteAct   = startOk || inChunk;
    ovf       = startOk && (startMode == ST_SKIP);
    serve     = idle && drainPend && !startOk;
    wrFull    = curBase + CNT_W'(curIdx);

    strb.passEn   = byteAct && (curMode == ST_DIRECT);
    strb.wrEn     = byteAct && (curMode == ST_STAGE);
    strb.passLast = (curIdx == curLen - LEN_W'(1));
    strb.rdEn     = (state == ST_DRAIN);
    strb.rdLast   = (rdIdx == held - CNT_W'(1));
    wrAddr        = ADDR_W'(wrFull);
    rdAddr        = ADDR_W'(rdIdx);
  end

  assign pktOffer  = startOk;
  assign chunkBusy = (state == ST_DRAIN) || drainPend;
  assign stall     = stallR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      idx       <= '0;
      lenR      <= '0;
      held      <= '0;
      baseR     <= '0;
      rdIdx     <= '0;
      drainPend <= 1'b0;
      stallR    <= 1'b0;
    end else begin
      if (startOk) begin
        lenR  <= chunkLen;
        baseR <= held;
        idx   <= LEN_W'(1);
        if (chunkLen != LEN_W'(1)) state <= startMode;
        if (startMode == ST_STAGE) held <= sum[CNT_W-1:0];
        else if (startMode == ST_SKIP) held <= '0;
      end else if (inChunk) begin
        idx <= idx + LEN_W'(1);
        if (idx == lenR - LEN_W'(1)) state <= ST_IDLE;
      end else if (state == ST_DRAIN) begin
        rdIdx <= rdIdx + CNT_W'(1);
        if (strb.rdLast) begin
          held  <= '0;
          state <= ST_IDLE;
        end
      end else if (serve && (held != '0)) begin
        state <= ST_DRAIN;
        rdIdx <= '0;
      end

      if (drainReq) drainPend <= 1'b1;
      else if (serve) drainPend <= 1'b0;

      if (ovf) stallR <= 1'b1;
      else if (stallClr) stallR <= 1'b0;
    end
  end

  // R1
  held_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    held <= CNT_W'(DEPTH));

  // R4
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stallR) |-> (held == '0));

  // R7
  stall_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stallR && !stallClr) |=> stallR);

  // R5
  drain_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_DRAIN) && strb.rdLast) |=> (held == '0));
endmodule

// File: rtl/tsb_datapath.sv
module tsb_datapath
  import tsb_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int BYTE_W = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  tsb_strb_t         strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [BYTE_W-1:0] chunkByte,
  output logic              pktValid,
  output logic [BYTE_W-1:0] pktByte,
  output logic              pktLast
);
  logic [BYTE_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (strb.wrEn) store[wrAddr] <= chunkByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktValid <= 1'b0;
      pktByte  <= '0;
      pktLast  <= 1'b0;
    end else begin
      pktValid <= strb.passEn || strb.rdEn;
      pktByte  <= strb.passEn ? chunkByte : store[rdAddr];
      pktLast  <= strb.passEn ? strb.passLast : (strb.rdEn && strb.rdLast);
    end
  end

  // R2
  pass_through_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.passEn |=> (pktValid && (pktByte == $past(chunkByte))));

  // R5
  one_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.passEn && strb.rdEn));
endmodule

// File: rtl/trace_stage_buf.sv
module trace_stage_buf
  import tsb_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int MAX_CHUNK = 16,
  parameter int BYTE_W    = 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LEN_W  = $clog2(MAX_CHUNK + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chunkStart,
  input  logic [LEN_W-1:0]  chunkLen,
  input  logic [BYTE_W-1:0] chunkByte,
  output logic              chunkBusy,
  output logic              pktOffer,
  output logic [LEN_W-1:0]  pktOfferLen,
  input  logic              pktAccept,
  output logic              pktValid,
  output logic [BYTE_W-1:0] pktByte,
  output logic              pktLast,
  input  logic              drainReq,
  input  logic              stallClr,
  output logic              stall
);
  tsb_strb_t         strb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  assign pktOfferLen = chunkLen;

  tsb_ctrl #(.DEPTH(DEPTH), .MAX_CHUNK(MAX_CHUNK)) i_ctrl (
    .clk(clk), .rstN(rstN), .chunkStart(chunkStart), .chunkLen(chunkLen),
    .pktAccept(pktAccept), .drainReq(drainReq), .stallClr(stallClr),
    .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .chunkBusy(chunkBusy), .pktOffer(pktOffer), .stall(stall)
  );

  tsb_datapath #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .chunkByte(chunkByte), .pktValid(pktValid), .pktByte(pktByte),
    .pktLast(pktLast)
  );
endmodule

// File: tb/test_trace_stage_buf.sv
`timescale 1ns/1ps
module test_trace_stage_buf;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       chunkStart = 1'b0;
  logic [4:0] chunkLen = '0;
  logic [7:0] chunkByte = '0;
  logic       chunkBusy, pktOffer, pktValid, pktLast, stall;
  logic [4:0] pktOfferLen;
  logic       pktAccept = 1'b0;
  logic [7:0] pktByte;
  logic       drainReq = 1'b0;
  logic       stallClr = 1'b0;

  always #2.5 clk = ~clk;

  trace_stage_buf i_trace_stage_buf (
    .clk(clk), .rstN(rstN), .chunkStart(chunkStart), .chunkLen(chunkLen),
    .chunkByte(chunkByte), .chunkBusy(chunkBusy), .pktOffer(pktOffer),
    .pktOfferLen(pktOfferLen), .pktAccept(pktAccept), .pktValid(pktValid),
    .pktByte(pktByte), .pktLast(pktLast), .drainReq(drainReq),
    .stallClr(stallClr), .stall(stall)
  );

  int nChecks = 0;
  int nFails  = 0;
  byte unsigned heldQ[$];
  byte unsigned expBytes[$];
  int           expLens[$];
  bit           mStall = 1'b0;
  int           curCnt = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  // output monitor: bytes compared in order with expectations
  always @(negedge clk) begin
    if (rstN && pktValid) begin
      if (expBytes.size() == 0) begin
        chk(1'b0, "R5/R8 unexpected output byte", pktByte, -1);
      end else begin
        chk(pktByte == expBytes[0], "R2/R3/R5 output byte", pktByte, expBytes[0]);
        void'(expBytes.pop_front());
      end
      curCnt++;
      if (pktLast) begin
        if (expLens.size() == 0) chk(1'b0, "R5 unexpected packet end", curCnt, -1);
        else begin
          chk(curCnt == expLens[0], "R2/R5 packet length at pktLast", curCnt, expLens[0]);
          void'(expLens.pop_front());
        end
        curCnt = 0;
      end
    end
  end

  function automatic void modelDrain();
    if (heldQ.size() > 0) begin
      foreach (heldQ[i]) expBytes.push_back(heldQ[i]);
      expLens.push_back(heldQ.size());
      heldQ.delete();
    end
  endfunction

  task automatic waitIdle();
    @(negedge clk);
    while (chunkBusy) @(negedge clk);
    @(negedge clk);
    chk(expBytes.size() == 0, "R5/R6 all expected bytes emitted", expBytes.size(), 0);
  endtask

  task automatic sendChunk(input int len, input bit acc, input bit withDrain, input bit withClr);
    byte unsigned b[16];
    bit ovf;
    for (int i = 0; i < 16; i++) b[i] = byte'($urandom);
    @(negedge clk);
    chunkStart = 1'b1; chunkLen = 5'(len); chunkByte = b[0];
    pktAccept = acc; drainReq = withDrain; stallClr = withClr;
    #1;
    chk(pktOffer == 1'b1, "R2 offer raised at chunk start", pktOffer, 1);
    chk(pktOfferLen == 5'(len), "R2 offer length", pktOfferLen, len);
    ovf = 1'b0;
    if (acc) begin
      for (int i = 0; i < len; i++) expBytes.push_back(b[i]);
      expLens.push_back(len);
    end else if (heldQ.size() + len > 64) begin
      ovf = 1'b1; mStall = 1'b1; heldQ.delete();
    end else begin
      for (int i = 0; i < len; i++) heldQ.push_back(b[i]);
    end
    if (withClr && !ovf) mStall = 1'b0;
    for (int i = 1; i < len; i++) begin
      @(negedge clk);
      chunkStart = 1'b0; pktAccept = 1'b0; drainReq = 1'b0; stallClr = 1'b0;
      chunkByte = b[i];
    end
    @(negedge clk);
    chunkStart = 1'b0; pktAccept = 1'b0; drainReq = 1'b0; stallClr = 1'b0;
    if (withDrain) begin
      modelDrain();
      waitIdle();
    end
  endtask

  task automatic doDrain();
    @(negedge clk);
    drainReq = 1'b1;
    @(negedge clk);
    drainReq = 1'b0;
    modelDrain();
    waitIdle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishRun();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(pktValid == 1'b0, "reset pktValid", pktValid, 0);
    chk(stall == 1'b0, "reset stall", stall, 0);
    chk(chunkBusy == 1'b0, "reset chunkBusy", chunkBusy, 0);

    // R6 drain of empty store
    doDrain();

    // R2 direct chunks, R3 staged chunks, R5 drain order
    sendChunk(5, 1'b1, 1'b0, 1'b0);
    sendChunk(1, 1'b1, 1'b0, 1'b0);
    sendChunk(3, 1'b0, 1'b0, 1'b0);
    sendChunk(7, 1'b0, 1'b0, 1'b0);
    sendChunk(16, 1'b1, 1'b0, 1'b0);
    doDrain();

    // R1 fill to exactly 64 without stall
    for (int i = 0; i < 4; i++) sendChunk(16, 1'b0, 1'b0, 1'b0);
    chk(stall == 1'b0, "R1 exact fill no stall", stall, 0);
    // R4 one more byte overflows
    sendChunk(1, 1'b0, 1'b0, 1'b0);
    chk(stall == 1'b1, "R4 overflow raises stall", stall, 1);
    doDrain();
    // R7 sticky then clear
    repeat (5) @(negedge clk);
    chk(stall == 1'b1, "R7 stall held", stall, 1);
    stallClr = 1'b1; @(negedge clk); stallClr = 1'b0;
    chk(stall == 1'b0, "R7 stall cleared", stall, 0);

    // R7 overflow and clear in same cycle
    for (int i = 0; i < 4; i++) sendChunk(16, 1'b0, 1'b0, 1'b0);
    sendChunk(2, 1'b0, 1'b0, 1'b1);
    chk(stall == 1'b1, "R7 set wins over clear", stall, 1);
    stallClr = 1'b1; @(negedge clk); stallClr = 1'b0; mStall = 1'b0;

    // R9 drain and chunk start together
    sendChunk(4, 1'b0, 1'b0, 1'b0);
    sendChunk(6, 1'b0, 1'b1, 1'b0);

    // R8 chunk start ignored while draining
    sendChunk(9, 1'b0, 1'b0, 1'b0);
    @(negedge clk); drainReq = 1'b1;
    @(negedge clk); drainReq = 1'b0; modelDrain();
    chk(chunkBusy == 1'b1, "R8 busy during drain", chunkBusy, 1);
    chunkStart = 1'b1; chunkLen = 5'd3; chunkByte = 8'hA5; pktAccept = 1'b0;
    #1;
    chk(pktOffer == 1'b0, "R8 no offer while busy", pktOffer, 0);
    @(negedge clk); chunkStart = 1'b0;
    @(negedge clk);
    @(negedge clk);
    waitIdle();
    doDrain();

    // R10 bad lengths
    @(negedge clk);
    chunkStart = 1'b1; chunkLen = 5'd0; pktAccept = 1'b0; #1;
    chk(pktOffer == 1'b0, "R10 zero length ignored", pktOffer, 0);
    @(negedge clk); chunkLen = 5'd17; #1;
    chk(pktOffer == 1'b0, "R10 length 17 ignored", pktOffer, 0);
    for (int i = 0; i < 17; i++) @(negedge clk);
    chunkStart = 1'b0;
    @(negedge clk);
    doDrain();

    // random traffic
    for (int n = 0; n < 400; n++) begin
      int len;
      len = $urandom_range(1, 16);
      sendChunk(len, bit'($urandom_range(0, 1)), ($urandom_range(0, 5) == 0), 1'b0);
      if ($urandom_range(0, 4) == 0) doDrain();
      if ($urandom_range(0, 9) == 0) begin
        chk(stall == mStall, "R4/R7 random stall state", stall, mStall);
        stallClr = 1'b1; @(negedge clk); stallClr = 1'b0; mStall = 1'b0;
      end
    end
    doDrain();
    chk(stall == mStall, "R4/R7 final stall state", stall, mStall);
    finishRun();
  end
endmodule